// File: doc/BRIEF.md
# Linked-Descriptor Memory Copy Channel

This block is one channel of a copy engine. Software gives it the address of a descriptor and pulses a start strobe. The channel reads the four-word descriptor from memory: byte count, source pointer, destination pointer and link pointer. It then copies the data one word at a time, reading each word and then writing it. After that it follows the link to the next descriptor. A zero link ends the walk. A link that points back to an earlier descriptor makes the channel loop for as long as it stays enabled.

Each side's pointer can stay fixed, which suits a peripheral data register, or it can step through memory. Words move in bursts whose length is set by a 3-bit code. The enable input is sampled only between bursts. Dropping it parks the channel with its count and pointers intact, and raising it again continues where the channel stopped. A one-cycle pulse marks the end of every descriptor.

Top module: `dma_chain_chan`

## Requirements
- R1: A start strobe while idle makes the channel read four words at the descriptor address, in ascending order at offsets 0, 4, 8 and 12. These words are taken as byte count, source pointer, destination pointer and link pointer. `cur_desc_o` shows the address of the descriptor being used.
- R2: Bits [3:0] of any descriptor or link address are treated as zero.
- R3: Bits [16:2] of the count word give the number of words to move. All other count bits are ignored. A count of zero completes the descriptor without any data access.
- R4: A direction field of 2 holds that side's pointer. Any other value advances it by 4 after each word. Source uses `src_dir_i` and destination uses `dst_dir_i`.
- R5: The burst code maps 0→1, 1→2, 3→4, 6→8, 7→16 and 5→32 words, and codes 2 and 4 give 1 word. A burst is cut short at the end of a descriptor.
- R6: `done_o` is high for exactly one cycle after the last word of each descriptor, including a zero-count descriptor.
- R7: A nonzero link starts the fetch of the next descriptor. A zero link returns the channel to idle with `active_o` low. A start strobe carrying a zero address is ignored.
- R8: A chain whose link points back to an earlier descriptor keeps running, and keeps `active_o` high, while `enable_i` stays high.
- R9: If `enable_i` is low at a burst boundary, the channel issues no memory requests and drops `active_o`. The current burst still finishes first. When `enable_i` rises again, the transfer continues without losing count or pointers.
- R10: Once a memory request is raised, it stays raised with a stable address and write flag until `mem_ack_i` is seen.
- R11: After reset the channel is idle: no request, `active_o` low, `done_o` low, `cur_desc_o` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| next_ptr_i | input | 32 | Descriptor address taken by the start strobe |
| fetch_i | input | 1 | Start strobe, used only while idle |
| enable_i | input | 1 | Run/pause control, sampled at burst boundaries |
| src_dir_i | input | 2 | Source pointer mode (2 hold, else increment) |
| dst_dir_i | input | 2 | Destination pointer mode (2 hold, else increment) |
| burst_i | input | 3 | Burst length code |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Request byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Request accepted; read data valid |
| mem_rdata_i | input | 32 | Read data |
| done_o | output | 1 | One-cycle end-of-descriptor pulse |
| active_o | output | 1 | Channel is working on a chain |
| cur_desc_o | output | 32 | Address of the current descriptor |

## Verification
A corrupted pointer or word counter shows up at the memory port within one read/write pair. Destination words land in the wrong place, or the number of writes before `done_o` is wrong. A wrong link latch shows as a bad fetch address or as `active_o` staying high after a zero link. A wrong burst counter shows only at a pause, as the number of writes that still occur after `enable_i` falls. For that reason the bench pauses right after the first write, using both a one-word burst and a sixteen-word burst.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_DESC, S_BURST, S_RD, S_WR, S_END, S_PAUSE
  } chan_state_e;

  localparam logic [1:0] DIR_HOLD = 2'd2;
  localparam int DESC_WORDS = 4;
  localparam int DESC_ALIGN_BITS = 4;
endpackage

// File: rtl/dma_burst_decode.sv
module dma_burst_decode #(
  parameter int BURST_W = 6
) (
  input  logic [2:0]         code_i,
  output logic [BURST_W-1:0] words_o
);
  always_comb begin
    unique case (code_i)
      3'd1:    words_o = BURST_W'(2);
      3'd3:    words_o = BURST_W'(4);
      3'd6:    words_o = BURST_W'(8);
      3'd7:    words_o = BURST_W'(16);
      3'd5:    words_o = BURST_W'(32);
      default: words_o = BURST_W'(1);
    endcase
  end
endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step
  import dma_chain_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        dir_i,
  output logic [ADDR_W-1:0] addr_o
);
  assign addr_o = (dir_i == DIR_HOLD) ? addr_i : addr_i + ADDR_W'(4);
endmodule

// File: rtl/dma_chain_chan.sv
module dma_chain_chan
  import dma_chain_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] next_ptr_i,
  input  logic              fetch_i,
  input  logic              enable_i,
  input  logic [1:0]        src_dir_i,
  input  logic [1:0]        dst_dir_i,
  input  logic [2:0]        burst_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              done_o,
  output logic              active_o,
  output logic [ADDR_W-1:0] cur_desc_o
);
  localparam int WORDS_W = CNT_W - 2;
  localparam int BURST_W = 6;
  localparam int NSIDE   = 2;
  localparam int IDX_W   = $clog2(DESC_WORDS);

  chan_state_e       state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] ptr_q, link_q;
  logic [ADDR_W-1:0] addr_q   [NSIDE];
  logic [ADDR_W-1:0] addr_nxt [NSIDE];
  logic [1:0]        dir      [NSIDE];
  logic [WORDS_W-1:0] words_q;
  logic [BURST_W-1:0] burst_q, burst_len, burst_take;
  logic [31:0]       data_q;
  logic [ADDR_W-1:0] start_ptr;
  logic              unused_bits;

  assign unused_bits = ^next_ptr_i[DESC_ALIGN_BITS-1:0];
  assign start_ptr   = {next_ptr_i[ADDR_W-1:DESC_ALIGN_BITS], {DESC_ALIGN_BITS{1'b0}}};
  assign dir[0] = src_dir_i;
  assign dir[1] = dst_dir_i;

  dma_burst_decode #(.BURST_W(BURST_W)) u_burst (.code_i(burst_i), .words_o(burst_len));

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    dma_addr_step #(.ADDR_W(ADDR_W)) u_step (
      .addr_i(addr_q[g]), .dir_i(dir[g]), .addr_o(addr_nxt[g])
    );
  end

  // burst never runs past the descriptor end
  assign burst_take = (WORDS_W'(burst_len) > words_q) ? words_q[BURST_W-1:0] : burst_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      ptr_q   <= '0;
      link_q  <= '0;
      words_q <= '0;
      burst_q <= '0;
      data_q  <= '0;
      for (int i = 0; i < NSIDE; i++) addr_q[i] <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (fetch_i && start_ptr != '0) begin
          ptr_q   <= start_ptr;
          idx_q   <= '0;
          state_q <= S_DESC;
        end
        S_DESC: if (mem_ack_i) begin
          unique case (idx_q)
            2'd0: words_q   <= mem_rdata_i[CNT_W-1:2];
            2'd1: addr_q[0] <= mem_rdata_i[ADDR_W-1:0];
            2'd2: addr_q[1] <= mem_rdata_i[ADDR_W-1:0];
            default: link_q <= {mem_rdata_i[ADDR_W-1:DESC_ALIGN_BITS], {DESC_ALIGN_BITS{1'b0}}};
          endcase
          idx_q <= idx_q + 1'b1;
          if (idx_q == IDX_W'(DESC_WORDS - 1)) state_q <= S_BURST;
        end
        S_BURST: begin
          if (words_q == '0)   state_q <= S_END;
          else if (!enable_i)  state_q <= S_PAUSE;
          else begin
            burst_q <= burst_take;
            state_q <= S_RD;
          end
        end
        S_RD: if (mem_ack_i) begin
          data_q  <= mem_rdata_i;
          state_q <= S_WR;
        end
        S_WR: if (mem_ack_i) begin
          for (int i = 0; i < NSIDE; i++) addr_q[i] <= addr_nxt[i];
          words_q <= words_q - 1'b1;
          burst_q <= burst_q - 1'b1;
          state_q <= (burst_q == BURST_W'(1)) ? S_BURST : S_RD;
        end
        S_END: begin
          if (link_q == '0) state_q <= S_IDLE;
          else begin
            ptr_q   <= link_q;
            idx_q   <= '0;
            state_q <= S_DESC;
          end
        end
        S_PAUSE: if (enable_i) state_q <= S_BURST;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o  = 1'b0;
    mem_we_o   = 1'b0;
    mem_addr_o = '0;
    unique case (state_q)
      S_DESC: begin
        mem_req_o  = 1'b1;
        mem_addr_o = ptr_q + ADDR_W'({idx_q, 2'b00});
      end
      S_RD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = addr_q[0];
      end
      S_WR: begin
        mem_req_o  = 1'b1;
        mem_we_o   = 1'b1;
        mem_addr_o = addr_q[1];
      end
      default: ;
    endcase
  end

  assign mem_wdata_o = data_q;
  assign done_o      = (state_q == S_END);
  assign active_o    = (state_q != S_IDLE) && (state_q != S_PAUSE);
  assign cur_desc_o  = ptr_q;

  p_req_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_chain_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && link_q == '0 |=> !active_o);

  p_quiet_when_parked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> !mem_req_o);

  p_burst_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RD || state_q == S_WR) |->
      burst_q != '0 && WORDS_W'(burst_q) <= words_q);

  p_desc_align_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> cur_desc_o[DESC_ALIGN_BITS-1:0] == '0);
endmodule

// File: tb/dma_chain_chan_bench.sv
module dma_chain_chan_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 7;
  localparam logic [31:0] FILL = 32'hDEAD_BEEF;
  localparam logic [31:0] SRC = 32'h400, DST = 32'h800, DA = 32'h100, DB = 32'h140;
  localparam logic [31:0] V_CNT [NV] = '{32'd32, 32'd24, 32'd20, 32'd16, 32'hFFF0_002B, 32'd0, 32'd40};
  localparam logic [1:0]  V_SD  [NV] = '{2'd0, 2'd1, 2'd2, 2'd0, 2'd0, 2'd0, 2'd2};
  localparam logic [1:0]  V_DD  [NV] = '{2'd0, 2'd0, 2'd0, 2'd2, 2'd3, 2'd0, 2'd2};
  localparam logic [2:0]  V_BU  [NV] = '{3'd0, 3'd3, 3'd1, 3'd6, 3'd7, 3'd2, 3'd5};
  localparam int          V_LAT [NV] = '{0, 1, 2, 0, 1, 0, 2};

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [31:0] next_ptr_i = '0;
  logic fetch_i = 1'b0, enable_i = 1'b1;
  logic [1:0] src_dir_i = '0, dst_dir_i = '0;
  logic [2:0] burst_i = '0;
  logic mem_req_o, mem_we_o, mem_ack_i, done_o, active_o;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i, cur_desc_o;

  dma_chain_chan u_dma_chain_chan (
    .clk_i, .rst_ni, .next_ptr_i, .fetch_i, .enable_i, .src_dir_i, .dst_dir_i,
    .burst_i, .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ack_i,
    .mem_rdata_i, .done_o, .active_o, .cur_desc_o
  );

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  // memory model with programmable ack latency
  logic [31:0] mem [1024];
  logic [31:0] rd_log [16];
  logic ack_q = 1'b0, pend = 1'b0, pwe = 1'b0;
  logic [31:0] rdata_q = '0, paddr = '0;
  logic pl_en = 1'b0;
  logic [31:0] pl_addr = '0, pl_data = '0;
  int lat = 0, wcnt = 0, wr_cnt = 0, rd_cnt = 0, dn_cnt = 0, hold_err = 0;

  assign mem_ack_i   = ack_q;
  assign mem_rdata_i = rdata_q;

  always @(posedge clk_i) begin
    if (pl_en) mem[pl_addr[11:2]] <= pl_data;
    if (done_o) dn_cnt <= dn_cnt + 1;
    if (!rst_ni) begin
      ack_q <= 1'b0; pend <= 1'b0; wcnt <= 0;
    end else begin
      ack_q <= 1'b0;
      if (mem_req_o && !ack_q) begin
        if (pend && (mem_addr_o != paddr || mem_we_o != pwe)) hold_err <= hold_err + 1;
        pend <= 1'b1; paddr <= mem_addr_o; pwe <= mem_we_o;
        if (wcnt >= lat) begin
          ack_q <= 1'b1; wcnt <= 0; pend <= 1'b0;
          if (mem_we_o) begin
            mem[mem_addr_o[11:2]] <= mem_wdata_o;
            wr_cnt <= wr_cnt + 1;
          end else begin
            rdata_q <= mem[mem_addr_o[11:2]];
            rd_log[rd_cnt % 16] <= mem_addr_o;
            rd_cnt <= rd_cnt + 1;
          end
        end else wcnt <= wcnt + 1;
      end
    end
  end

  int n_chk = 0, n_fail = 0;
  logic fin = 1'b0;
  logic [31:0] expv [64];

  function automatic logic [31:0] pat(input logic [31:0] a);
    return 32'h5A00_0000 ^ a;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put_word(input logic [31:0] a, input logic [31:0] d);
    pl_en = 1'b1; pl_addr = a; pl_data = d;
    @(negedge clk_i);
    pl_en = 1'b0;
  endtask

  task automatic put_desc(input logic [31:0] at, input logic [31:0] c,
                          input logic [31:0] s, input logic [31:0] d, input logic [31:0] n);
    put_word(at, c); put_word(at + 4, s); put_word(at + 8, d); put_word(at + 12, n);
  endtask

  task automatic clear_dst();
    for (int i = 0; i < 64; i++) put_word(DST + 32'(i * 4), FILL);
  endtask

  task automatic start(input logic [31:0] p);
    next_ptr_i = p; fetch_i = 1'b1;
    @(negedge clk_i);
    fetch_i = 1'b0;
  endtask

  task automatic wait_done(input int target);
    for (int k = 0; k < 20000 && dn_cnt < target; k++) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
  endtask

  // expected destination image for a single descriptor
  task automatic model_copy(input int words, input logic [1:0] sd, input logic [1:0] dd);
    logic [31:0] s, d;
    s = SRC; d = DST;
    for (int i = 0; i < 64; i++) expv[i] = FILL;
    for (int i = 0; i < words; i++) begin
      expv[(d - DST) >> 2] = pat(s);
      if (sd != 2'd2) s = s + 4;
      if (dd != 2'd2) d = d + 4;
    end
  endtask

  function automatic int mism();
    int m = 0;
    for (int i = 0; i < 64; i++) if (mem[(DST >> 2) + i] !== expv[i]) m++;
    return m;
  endfunction

  initial begin
    int w0, d0, r0, words;
    for (int i = 0; i < 64; i++) put_word(SRC + 32'(i * 4), pat(SRC + 32'(i * 4)));
    // R11 reset state
    check("R11 req", 32'(mem_req_o), 0);
    check("R11 active", 32'(active_o), 0);
    check("R11 done", 32'(done_o), 0);
    check("R11 cur_desc", cur_desc_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // table-driven single descriptors: R3 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      clear_dst();
      put_desc(DA, V_CNT[v], SRC, DST, 0);
      src_dir_i = V_SD[v]; dst_dir_i = V_DD[v]; burst_i = V_BU[v]; lat = V_LAT[v];
      words = int'(V_CNT[v][16:2]);
      w0 = wr_cnt; d0 = dn_cnt;
      start(DA);
      wait_done(d0 + 1);
      model_copy(words, V_SD[v], V_DD[v]);
      check($sformatf("R3 R4 data vec%0d", v), 32'(mism()), 0);
      check($sformatf("R3 R5 writes vec%0d", v), 32'(wr_cnt - w0), 32'(words));
      check($sformatf("R6 done vec%0d", v), 32'(dn_cnt - d0), 1);
      check($sformatf("R7 idle vec%0d", v), 32'(active_o), 0);
    end
    src_dir_i = 0; dst_dir_i = 0; lat = 1;

    // R1 R2 fetch order and alignment
    put_desc(DA, 32'd4, SRC, DST, 0);
    r0 = rd_cnt; d0 = dn_cnt; burst_i = 0;
    start(DA | 32'hB);
    wait_done(d0 + 1);
    for (int k = 0; k < 4; k++)
      check($sformatf("R1 R2 fetch addr %0d", k), rd_log[(r0 + k) % 16], DA + 32'(4 * k));
    check("R1 cur_desc", cur_desc_o, DA);

    // R7 zero start address ignored
    r0 = rd_cnt;
    start(32'h0000_000C);
    repeat (6) @(negedge clk_i);
    check("R7 zero start active", 32'(active_o), 0);
    check("R7 zero start reads", 32'(rd_cnt - r0), 0);

    // R7 two-link chain
    clear_dst();
    put_desc(DA, 32'd8, SRC, DST, DB);
    put_desc(DB, 32'd8, SRC + 8, DST + 8, 0);
    d0 = dn_cnt;
    start(DA);
    wait_done(d0 + 2);
    model_copy(4, 2'd0, 2'd0);
    check("R7 chain data", 32'(mism()), 0);
    check("R7 chain dones", 32'(dn_cnt - d0), 2);
    check("R7 chain last desc", cur_desc_o, DB);
    check("R7 chain idle", 32'(active_o), 0);

    // R9 pause with one-word bursts
    clear_dst();
    put_desc(DA, 32'd32, SRC, DST, 0);
    burst_i = 3'd0; w0 = wr_cnt; d0 = dn_cnt;
    start(DA);
    for (int k = 0; k < 2000 && wr_cnt == w0; k++) @(negedge clk_i);
    enable_i = 1'b0;
    repeat (40) @(negedge clk_i);
    check("R9 R5 writes while paused b1", 32'(wr_cnt - w0), 1);
    check("R9 parked active", 32'(active_o), 0);
    check("R9 parked req", 32'(mem_req_o), 0);
    enable_i = 1'b1;
    wait_done(d0 + 1);
    model_copy(8, 2'd0, 2'd0);
    check("R9 resume data b1", 32'(mism()), 0);

    // R9 R5 pause inside a sixteen-word burst
    clear_dst();
    put_desc(DA, 32'd128, SRC, DST, 0);
    burst_i = 3'd7; w0 = wr_cnt; d0 = dn_cnt;
    start(DA);
    for (int k = 0; k < 2000 && wr_cnt == w0; k++) @(negedge clk_i);
    enable_i = 1'b0;
    repeat (120) @(negedge clk_i);
    check("R9 R5 writes while paused b16", 32'(wr_cnt - w0), 16);
    enable_i = 1'b1;
    wait_done(d0 + 1);
    model_copy(32, 2'd0, 2'd0);
    check("R9 resume data b16", 32'(mism()), 0);
    check("R9 resume writes b16", 32'(wr_cnt - w0), 32);

    // R8 ring
    clear_dst();
    put_desc(DA, 32'd8, SRC, DST, DB);
    put_desc(DB, 32'd8, SRC + 8, DST + 8, DA);
    burst_i = 3'd1; d0 = dn_cnt;
    start(DA);
    for (int k = 0; k < 5000 && dn_cnt < d0 + 5; k++) @(negedge clk_i);
    check("R8 ring dones", 32'(dn_cnt - d0 >= 5), 1);
    check("R8 ring active", 32'(active_o), 1);
    check("R8 ring desc", 32'(cur_desc_o == DA || cur_desc_o == DB), 1);
    model_copy(4, 2'd0, 2'd0);
    check("R8 ring data", 32'(mism()), 0);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R11 after reset active", 32'(active_o), 0);

    check("R10 request hold violations", 32'(hold_err), 0);

    fin = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!fin) begin
      $display("FAIL watchdog R1-chain actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk + 1, n_fail + 1);
      $finish;
    end
  end
endmodule